// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Arbiter

This block sits beside a processor core and watches the instruction stream it executes. When an instruction belongs to the coprocessor group, the block works out which of three kinds of operation it is: an internal coprocessor data operation, a move between core and coprocessor registers, or a memory transfer whose address the core generates. It also extracts the 4-bit coprocessor number carried by the instruction. It then searches a set of attached units for one that claims that number. A unit claims numbers through a 16-bit mask, so one unit may own several numbers.

If no unit claims the number, the core is told to take an undefined-instruction trap so that software can emulate the operation. If a unit claims it, the core is stalled while the arbiter waits for that unit's answer. An accept releases the core with a one-cycle go pulse that names the unit, the number and the kind of operation. A busy answer keeps the core stalled. No answer at all leads to a trap. An interrupt request from the core abandons a pending wait without dispatching the instruction and without trapping.

The go-or-trap outcome is final before the core starts the instruction. Anything a unit signals after the go is ignored, so a fault inside a unit never surfaces at the core side. When two units claim the same number, the lower-indexed unit is used and a sticky configuration-error flag is raised.

Top module: `copro_dispatch`

## Requirements
- R1: Kind decode. Instruction bits [27:25] = 110 means memory transfer (reported kind 3). Bits [27:24] = 1110 with bit 4 = 0 means data operation (kind 1). Bits [27:24] = 1110 with bit 4 = 1 means register move (kind 2). The coprocessor number is bits [11:8]. Kind and number are reported on `op_kind` and `op_num` together with every go or trap.
- R2: An instruction that is not in the coprocessor group produces no stall, no go and no trap.
- R3: A coprocessor instruction whose number no unit claims raises `core_trap` for exactly one cycle, one clock after it was presented, and never raises `core_stall`.
- R4: A coprocessor instruction whose number is claimed raises `core_stall` one clock after it was presented.
- R5: While stalled, an accept from the owning unit ends the stall on the next clock. It does so with a one-cycle `core_go` and a one-hot `disp_sel` that names the owning unit.
- R6: While stalled, a busy from the owning unit that comes without an accept keeps the core stalled. Neither accept nor busy from the owner ends the stall with a one-cycle trap. Answers from units that do not own the number are ignored.
- R7: A `irq_req` while stalled, without an accept from the owner, ends the stall on the next clock with neither go nor trap.
- R8: When several units claim the decoded number, the lowest-indexed one is the owner, and `cfg_err` goes high and stays high until reset.
- R9: `core_go` and `core_trap` are never high together. Unit answers that arrive while no instruction is pending have no effect on the outputs.
- R10: After reset, `core_stall`, `core_go`, `core_trap`, `cfg_err` and `disp_sel` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| irq_req | input | 1 | Core interrupt request; abandons a pending wait |
| claim_mask | input | N_UNITS*16 | Per-unit claimed numbers, unit i in bits [16i+15:16i] |
| unit_accept | input | N_UNITS | Per-unit accept answer |
| unit_busy | input | N_UNITS | Per-unit busy answer |
| core_stall | output | 1 | Core must hold the current instruction |
| core_go | output | 1 | One-cycle pulse: instruction dispatched, core may commit |
| core_trap | output | 1 | One-cycle pulse: take undefined-instruction trap |
| disp_sel | output | N_UNITS | One-hot owning unit during `core_go`, zero otherwise |
| op_num | output | 4 | Coprocessor number of the last decoded instruction |
| op_kind | output | 2 | Kind of the last decoded instruction (1 data, 2 register, 3 memory) |
| cfg_err | output | 1 | Sticky: a number was claimed by more than one unit |

## Verification
The assertions take for granted that the core presents an instruction for a single cycle and does not present another one until the previous one has ended in a go, a trap or a cancel. They also take for granted that the claim masks stay stable while an instruction is pending. The stimulus keeps to this by driving each instruction as a one-cycle pulse and changing masks only between instructions. It then waits for the outcome, holding the owner's answer for a random number of busy cycles first. It also drives accepts on units that do not own the number, and accepts while nothing is pending, so that the ignore rules are exercised.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
    localparam int NUM_W     = 4;
    localparam int NUM_SLOTS = 1 << NUM_W;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_DATA = 2'd1,
        KIND_REG  = 2'd2,
        KIND_MEM  = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;
endpackage

// File: rtl/cpd_kind_decode.sv
module cpd_kind_decode
    import cpd_pkg::*;
(
    input  logic [31:0]      instr,
    output kind_e            kind,
    output logic [NUM_W-1:0] num
);
    logic unused_bits;
    assign unused_bits = ^{instr[31:28], instr[23:12], instr[7:5], instr[3:0]};

    always_comb begin
        kind = KIND_NONE;
        if (instr[27:25] == 3'b110) begin
            kind = KIND_MEM;
        end else if (instr[27:24] == 4'b1110) begin
            kind = instr[4] ? KIND_REG : KIND_DATA;
        end
        num = instr[8 +: NUM_W];
    end
endmodule

// File: rtl/cpd_claim_resolve.sv
module cpd_claim_resolve
    import cpd_pkg::*;
#(
    parameter int N_UNITS = 4,
    localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic [N_UNITS*NUM_SLOTS-1:0] claim_mask,
    input  logic [NUM_W-1:0]             num,
    output logic                         any_hit,
    output logic                         multi_hit,
    output logic [UNIT_W-1:0]            owner
);
    logic [N_UNITS-1:0] hit;

    for (genvar g = 0; g < N_UNITS; g++) begin : g_hit
        assign hit[g] = claim_mask[g*NUM_SLOTS + int'(num)];
    end

    always_comb begin
        owner = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                owner = UNIT_W'(i);
            end
        end
        any_hit   = |hit;
        multi_hit = ($countones(hit) > 1);
    end
endmodule

// File: rtl/copro_dispatch.sv
module copro_dispatch
    import cpd_pkg::*;
#(
    parameter int N_UNITS = 4,
    localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         instr_valid,
    input  logic [31:0]                  instr,
    input  logic                         irq_req,
    input  logic [N_UNITS*NUM_SLOTS-1:0] claim_mask,
    input  logic [N_UNITS-1:0]           unit_accept,
    input  logic [N_UNITS-1:0]           unit_busy,
    output logic                         core_stall,
    output logic                         core_go,
    output logic                         core_trap,
    output logic [N_UNITS-1:0]           disp_sel,
    output logic [NUM_W-1:0]             op_num,
    output logic [1:0]                   op_kind,
    output logic                         cfg_err
);
    typedef struct packed {
        state_e             state;
        logic [UNIT_W-1:0]  owner;
        logic [NUM_W-1:0]   num;
        kind_e              kind;
        logic               stall;
        logic               go;
        logic               trap;
        logic [N_UNITS-1:0] sel;
        logic               cfg_err;
    } regs_t;

    regs_t r_d, r_q;

    kind_e             dec_kind;
    logic [NUM_W-1:0]  dec_num;
    logic              any_hit;
    logic              multi_hit;
    logic [UNIT_W-1:0] own_idx;
    logic              own_acc;
    logic              own_busy;

    cpd_kind_decode u_dec (
        .instr (instr),
        .kind  (dec_kind),
        .num   (dec_num)
    );

    cpd_claim_resolve #(.N_UNITS(N_UNITS)) u_res (
        .claim_mask (claim_mask),
        .num        (dec_num),
        .any_hit    (any_hit),
        .multi_hit  (multi_hit),
        .owner      (own_idx)
    );

    assign own_acc  = unit_accept[r_q.owner];
    assign own_busy = unit_busy[r_q.owner];

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.trap = 1'b0;
        r_d.sel  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (instr_valid && (dec_kind != KIND_NONE)) begin
                    r_d.num  = dec_num;
                    r_d.kind = dec_kind;
                    if (multi_hit) begin
                        r_d.cfg_err = 1'b1;
                    end
                    if (any_hit) begin
                        r_d.state = ST_WAIT;
                        r_d.owner = own_idx;
                        r_d.stall = 1'b1;
                    end else begin
                        r_d.trap = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (own_acc) begin
                    r_d.go               = 1'b1;
                    r_d.sel[r_q.owner]   = 1'b1;
                    r_d.stall            = 1'b0;
                    r_d.state            = ST_IDLE;
                end else if (irq_req) begin
                    r_d.stall = 1'b0;
                    r_d.state = ST_IDLE;
                end else if (!own_busy) begin
                    r_d.trap  = 1'b1;
                    r_d.stall = 1'b0;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, owner: '0, num: '0, kind: KIND_NONE,
                     stall: 1'b0, go: 1'b0, trap: 1'b0, sel: '0, cfg_err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign core_stall = r_q.stall;
    assign core_go    = r_q.go;
    assign core_trap  = r_q.trap;
    assign disp_sel   = r_q.sel;
    assign op_num     = r_q.num;
    assign op_kind    = r_q.kind;
    assign cfg_err    = r_q.cfg_err;
endmodule

// File: rtl/copro_dispatch_chk.sv
module copro_dispatch_chk #(
    parameter int N_UNITS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [3:0]         instr_hi,
    input logic               irq_req,
    input logic [N_UNITS-1:0] unit_accept,
    input logic [N_UNITS-1:0] unit_busy,
    input logic               core_stall,
    input logic               core_go,
    input logic               core_trap,
    input logic [N_UNITS-1:0] disp_sel,
    input logic               cfg_err
);
    logic in_group;
    assign in_group = (instr_hi[3:1] == 3'b110) || (instr_hi == 4'b1110);

    p_go_trap_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_go && core_trap));

    p_go_after_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_go |-> $past(core_stall));

    p_go_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_go |-> ($countones(disp_sel) == 1));

    p_sel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !core_go |-> (disp_sel == '0));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_stall && !irq_req && (unit_accept == '0) && (&unit_busy)) |=> core_stall);

    p_irq_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_stall && irq_req && (unit_accept == '0)) |=> (!core_stall && !core_go && !core_trap));

    p_outside_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall && instr_valid && !in_group) |=> (!core_stall && !core_go && !core_trap));

    p_idle_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall && !instr_valid) |=> !core_go);

    p_cfg_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind copro_dispatch copro_dispatch_chk #(.N_UNITS(N_UNITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_hi    (instr[27:24]),
    .irq_req     (irq_req),
    .unit_accept (unit_accept),
    .unit_busy   (unit_busy),
    .core_stall  (core_stall),
    .core_go     (core_go),
    .core_trap   (core_trap),
    .disp_sel    (disp_sel),
    .cfg_err     (cfg_err)
);

// File: tb/sim_copro_dispatch.sv
`timescale 1ns/1ps
module sim_copro_dispatch;
    localparam int N = 4;
    localparam int S = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           instr_valid = 1'b0;
    logic [31:0]    instr = '0;
    logic           irq_req = 1'b0;
    logic [N*S-1:0] claim_mask = '0;
    logic [N-1:0]   unit_accept = '0;
    logic [N-1:0]   unit_busy = '0;
    logic           core_stall, core_go, core_trap, cfg_err;
    logic [N-1:0]   disp_sel;
    logic [3:0]     op_num;
    logic [1:0]     op_kind;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit exp_cfg = 1'b0;

    always #2.5 clk = ~clk;

    copro_dispatch #(.N_UNITS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .irq_req(irq_req), .claim_mask(claim_mask), .unit_accept(unit_accept),
        .unit_busy(unit_busy), .core_stall(core_stall), .core_go(core_go),
        .core_trap(core_trap), .disp_sel(disp_sel), .op_num(op_num),
        .op_kind(op_kind), .cfg_err(cfg_err)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int exp_owner(logic [N*S-1:0] m, int num);
        for (int i = 0; i < N; i++) if (m[i*S + num]) return i;
        return -1;
    endfunction

    function automatic int claim_count(logic [N*S-1:0] m, int num);
        int c = 0;
        for (int i = 0; i < N; i++) if (m[i*S + num]) c++;
        return c;
    endfunction

    // kind 0 = outside group, 1 data, 2 register, 3 memory
    function automatic logic [31:0] make_instr(int kind, int num);
        logic [31:0] w = $urandom;
        int hi;
        case (kind)
            3: w[27:25] = 3'b110;
            1: begin w[27:24] = 4'b1110; w[4] = 1'b0; end
            2: begin w[27:24] = 4'b1110; w[4] = 1'b1; end
            default: begin
                hi = $urandom_range(0, 12);
                w[27:24] = (hi == 12) ? 4'hF : hi[3:0];
            end
        endcase
        w[11:8] = num[3:0];
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; instr_valid = 1'b0; irq_req = 1'b0;
        unit_accept = '0; unit_busy = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        exp_cfg = 1'b0;
        chk("R10", "stall", core_stall, 0);
        chk("R10", "go", core_go, 0);
        chk("R10", "trap", core_trap, 0);
        chk("R10", "cfg_err", cfg_err, 0);
        chk("R10", "disp_sel", disp_sel, 0);
    endtask

    // resp: 0 accept, 1 no answer, 2 interrupt
    task automatic run_one(int kind, int num, int resp, int busy_n);
        int own;
        own = exp_owner(claim_mask, num);
        @(negedge clk);
        instr = make_instr(kind, num);
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (kind == 0) begin
            chk("R2", "stall", core_stall, 0);
            chk("R2", "go", core_go, 0);
            chk("R2", "trap", core_trap, 0);
            return;
        end
        if (claim_count(claim_mask, num) > 1) exp_cfg = 1'b1;
        chk("R8", "cfg_err", cfg_err, exp_cfg);
        if (own < 0) begin
            chk("R3", "trap", core_trap, 1);
            chk("R3", "stall", core_stall, 0);
            chk("R1", "op_num", op_num, num);
            chk("R1", "op_kind", op_kind, kind);
            @(negedge clk);
            chk("R3", "trap one cycle", core_trap, 0);
            return;
        end
        chk("R4", "stall", core_stall, 1);
        chk("R1", "op_kind", op_kind, kind);
        for (int b = 0; b < busy_n; b++) begin
            unit_busy = N'($urandom);
            unit_busy[own] = 1'b1;
            unit_accept = N'($urandom);
            unit_accept[own] = 1'b0;
            @(negedge clk);
            chk("R6", "stall held", core_stall, 1);
            chk("R6", "no go while busy", core_go, 0);
            chk("R6", "no trap while busy", core_trap, 0);
        end
        unit_accept = '0;
        unit_busy = '0;
        if (resp == 0) begin
            unit_accept[own] = 1'b1;
            unit_busy[own] = 1'($urandom);
        end else if (resp == 2) begin
            irq_req = 1'b1;
            unit_busy[own] = 1'($urandom);
        end
        @(negedge clk);
        irq_req = 1'b0;
        unit_accept = '1;
        unit_busy = '0;
        chk("R9", "go/trap exclusive", {31'd0, core_go & core_trap}, 0);
        if (resp == 0) begin
            chk("R5", "go", core_go, 1);
            chk("R5", "disp_sel", disp_sel, 1 << own);
            chk("R5", "stall released", core_stall, 0);
            chk("R1", "op_num", op_num, num);
        end else if (resp == 1) begin
            chk("R6", "trap on no answer", core_trap, 1);
            chk("R6", "stall released", core_stall, 0);
        end else begin
            chk("R7", "stall cancelled", core_stall, 0);
            chk("R7", "no go", core_go, 0);
            chk("R7", "no trap", core_trap, 0);
        end
        @(negedge clk);
        unit_accept = '0;
        chk("R9", "idle accept ignored go", core_go, 0);
        chk("R9", "idle accept ignored trap", core_trap, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // directed: nothing claimed
        claim_mask = '0;
        run_one(1, 5, 0, 0);
        run_one(3, 0, 0, 0);
        // directed: outside group
        run_one(0, 9, 0, 0);
        // directed: one unit owns several numbers
        claim_mask = '0;
        claim_mask[1*S + 3] = 1'b1;
        claim_mask[1*S + 12] = 1'b1;
        run_one(2, 3, 0, 2);
        run_one(1, 12, 1, 1);
        chk("R8", "no conflict yet", cfg_err, 0);
        // directed: conflict, lowest index wins
        claim_mask[0*S + 7] = 1'b1;
        claim_mask[2*S + 7] = 1'b1;
        run_one(1, 7, 0, 1);
        run_one(3, 3, 2, 3);
        chk("R8", "cfg_err sticky", cfg_err, 1);
        do_reset();
        chk("R8", "cfg_err cleared by reset", cfg_err, 0);

        // random sweep over all numbers
        for (int set = 0; set < 12; set++) begin
            for (int u = 0; u < N; u++) claim_mask[u*S +: S] = 16'($urandom & $urandom);
            for (int n = 0; n < S; n++) begin
                run_one($urandom_range(0, 3), n, $urandom_range(0, 2), $urandom_range(0, 3));
            end
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule